// File: doc/BRIEF.md
# Grouped Compare Latch Loader

This block holds seven double-buffered compare channels, numbered 0 to 6. Software writes each channel's compare register through a per-channel write strobe. The timer's comparators only see a shadow latch, and the block decides when register data moves into that latch. Each channel carries a 2-bit load-control field that picks the transfer event: the write itself, the counter reaching zero, the counter reaching its period, or a choice that depends on the counting mode.

A 2-bit group-mode input can tie channels 1 to 6 into groups. The possible layouts are pairs, triples, or one group of six. Channel 0 never joins a group. Inside a group, the lowest-numbered member is the leader, and its load-control field sets the transfer event for every member. A grouped transfer happens only when two things are true: every member's register has been written since the group's previous transfer, and the leader's event then fires. This lets software update several duty values and have them take effect together.

Top module: `cmp_latch_group`

## Requirements
- R1: While reset is asserted and right after it is released, every latch output reads zero.
- R2: An ungrouped channel whose load control is 00 copies the written value into its latch at the same clock edge that captures the write.
- R3: An ungrouped channel with load control 01 loads its register into its latch only on a counter-at-zero pulse. A counter-at-period pulse has no effect on it.
- R4: An ungrouped channel with load control 10 loads only on counter-at-zero while the up/down flag is 0. While the flag is 1, it loads on either counter-at-zero or counter-at-period.
- R5: An ungrouped channel with load control 11 loads only on a counter-at-period pulse.
- R6: Group mode 01 forms the groups {1,2}, {3,4} and {5,6}, each led by its lowest member. The leader's load control sets the event for the whole group, and a member's own field is ignored.
- R7: A grouped load does not happen if any member's register has not been written since the group's last load, even when the event fires.
- R8: A write of the value already held in a register still counts as a write toward a grouped load.
- R9: A write to a group member in the same cycle as the leader's event does not count for that event. The next event after it does count.
- R10: Group mode 10 forms {1,2,3} and {4,5,6}. Group mode 11 forms {1..6}. Channel 0 always stays ungrouped and follows its own field.
- R11: When a group leader's load control is 00, grouping is off for that group, and each member's latch takes its own written value at the write edge.
- R12: A grouped load clears the written status of every member. A later event with only some members rewritten does not load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_sel | input | 7 | Write strobe per channel, bit n selects channel n |
| wr_data | input | DATA_W | Data written to the strobed registers |
| grp_mode | input | 2 | Grouping layout: 00 none, 01 pairs, 10 triples, 11 all of 1..6 |
| ld_ctl | input | 14 | Load control per channel, bits [2n+1:2n] for channel n: 00 on write, 01 at zero, 10 zero or mode-dependent, 11 at period |
| at_zero | input | 1 | One-cycle pulse when the counter reaches zero |
| at_period | input | 1 | One-cycle pulse when the counter reaches its period |
| updn_mode | input | 1 | 1 when the counter runs in up/down mode |
| latch_out | output | 7*DATA_W | Latch values, channel n at bits [DATA_W*(n+1)-1:DATA_W*n] |

## Verification
The delicate overlap is a register write landing in the same cycle as the group leader's load event. In that cycle the group's written status is cleared and set at once. The bench provokes this by writing the last missing member of a pair exactly in the cycle of an at-zero pulse. It then confirms that neither latch moves on that pulse. It also confirms that both latches take the new values on the following pulse, without any further write.

// File: rtl/cmp_grp_pkg.sv
package cmp_grp_pkg;
  localparam int NCH  = 7;
  localparam int CH_W = $clog2(NCH);

  typedef enum logic [1:0] {
    LD_WRITE  = 2'b00,
    LD_ZERO   = 2'b01,
    LD_ZMIX   = 2'b10,
    LD_PERIOD = 2'b11
  } ld_sel_e;

  typedef enum logic [1:0] {
    GRP_NONE    = 2'b00,
    GRP_PAIRS   = 2'b01,
    GRP_TRIPLES = 2'b10,
    GRP_ALL     = 2'b11
  } grp_mode_e;

  // leader channel index of channel ch under a grouping layout
  function automatic logic [CH_W-1:0] leader_of(grp_mode_e m, logic [CH_W-1:0] ch);
    logic [CH_W-1:0] r;
    r = ch;
    if (ch != '0) begin
      case (m)
        GRP_PAIRS:   r = ch[0] ? ch : ch - CH_W'(1);
        GRP_TRIPLES: r = (ch <= CH_W'(3)) ? CH_W'(1) : CH_W'(4);
        GRP_ALL:     r = CH_W'(1);
        default:     r = ch;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/cgl_group_map.sv
module cgl_group_map
  import cmp_grp_pkg::*;
(
  input  logic [1:0]       grp_mode,
  input  logic [2*NCH-1:0] ld_ctl,
  input  logic [NCH-1:0]   written,
  output logic [2*NCH-1:0] eff_ctl,
  output logic [NCH-1:0]   grp_ready
);
  grp_mode_e       mode;
  logic [CH_W-1:0] ldr [NCH];

  assign mode = grp_mode_e'(grp_mode);

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      logic grouped;
      assign ldr[c]  = leader_of(mode, CH_W'(c));
      assign grouped = (mode != GRP_NONE) && (c != 0);
      assign eff_ctl[2*c +: 2] = grouped ? ld_ctl[2*ldr[c] +: 2] : ld_ctl[2*c +: 2];
    end
  endgenerate

  // a channel is ready when every member sharing its leader has been written
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      grp_ready[i] = 1'b1;
      for (int m = 0; m < NCH; m++) begin
        if ((mode != GRP_NONE) && (i != 0) && (m != 0) && (ldr[m] == ldr[i]) && !written[m])
          grp_ready[i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/cgl_event_dec.sv
module cgl_event_dec
  import cmp_grp_pkg::*;
(
  input  logic [2*NCH-1:0] eff_ctl,
  input  logic             at_zero,
  input  logic             at_period,
  input  logic             updn_mode,
  output logic [NCH-1:0]   fire,
  output logic [NCH-1:0]   direct
);
  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_dec
      ld_sel_e sel;
      assign sel = ld_sel_e'(eff_ctl[2*c +: 2]);
      always_comb begin
        direct[c] = 1'b0;
        fire[c]   = 1'b0;
        case (sel)
          LD_WRITE:  direct[c] = 1'b1;
          LD_ZERO:   fire[c]   = at_zero;
          LD_ZMIX:   fire[c]   = at_zero | (updn_mode & at_period);
          LD_PERIOD: fire[c]   = at_period;
          default:   fire[c]   = 1'b0;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/cgl_channel.sv
module cgl_channel #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              direct,
  input  logic              fire,
  input  logic              ready,
  output logic [DATA_W-1:0] latch_q,
  output logic              written_q
);
  logic [DATA_W-1:0] reg_q, reg_nxt, latch_nxt;
  logic              reg_en, latch_en, flag_en, flag_nxt, evt_load;

  always_comb begin
    evt_load  = fire & ready & ~direct;
    reg_en    = wr;
    reg_nxt   = wr_data;
    latch_en  = (direct & wr) | evt_load;
    latch_nxt = (direct & wr) ? wr_data : reg_q;
    flag_en   = wr | evt_load | direct;
    flag_nxt  = wr & ~direct;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q     <= '0;
      latch_q   <= '0;
      written_q <= 1'b0;
    end else begin
      if (reg_en)   reg_q     <= reg_nxt;
      if (latch_en) latch_q   <= latch_nxt;
      if (flag_en)  written_q <= flag_nxt;
    end
  end
endmodule

// File: rtl/cmp_latch_group.sv
module cmp_latch_group
  import cmp_grp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        wr_sel,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [1:0]            grp_mode,
  input  logic [2*NCH-1:0]      ld_ctl,
  input  logic                  at_zero,
  input  logic                  at_period,
  input  logic                  updn_mode,
  output logic [DATA_W*NCH-1:0] latch_out
);
  logic [1:0]       rst_sync;
  logic             rst_ns;
  logic [2*NCH-1:0] eff_ctl;
  logic [NCH-1:0]   grp_ready, written, fire, direct;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  cgl_group_map u_map (
    .grp_mode  (grp_mode),
    .ld_ctl    (ld_ctl),
    .written   (written),
    .eff_ctl   (eff_ctl),
    .grp_ready (grp_ready)
  );

  cgl_event_dec u_dec (
    .eff_ctl   (eff_ctl),
    .at_zero   (at_zero),
    .at_period (at_period),
    .updn_mode (updn_mode),
    .fire      (fire),
    .direct    (direct)
  );

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_chan
      cgl_channel #(.DATA_W(DATA_W)) u_chan (
        .clk       (clk),
        .rst_n     (rst_ns),
        .wr        (wr_sel[c]),
        .wr_data   (wr_data),
        .direct    (direct[c]),
        .fire      (fire[c]),
        .ready     (grp_ready[c]),
        .latch_q   (latch_out[DATA_W*c +: DATA_W]),
        .written_q (written[c])
      );
    end
  endgenerate
endmodule

// File: rtl/cmp_latch_group_chk.sv
module cmp_latch_group_chk
  import cmp_grp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NCH-1:0]        wr_sel,
  input logic [DATA_W-1:0]     wr_data,
  input logic [1:0]            grp_mode,
  input logic [2*NCH-1:0]      ld_ctl,
  input logic                  at_zero,
  input logic                  at_period,
  input logic [DATA_W*NCH-1:0] latch_out
);
  logic [DATA_W-1:0] l0, l2;
  assign l0 = latch_out[0 +: DATA_W];
  assign l2 = latch_out[2*DATA_W +: DATA_W];

  a_r2_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel[0] && ld_ctl[1:0] == 2'b00) |=> (l0 == $past(wr_data)));

  a_r3_zero_only: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ctl[1:0] == 2'b01 && !at_zero) |=> $stable(l0));

  a_r5_period_only: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ctl[1:0] == 2'b11 && !at_period) |=> $stable(l0));

  a_r7_no_event_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_mode == 2'b01 && ld_ctl[3:2] != 2'b00 && !at_zero && !at_period) |=> $stable(l2));

  a_r11_leader_off: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_mode != 2'b00 && ld_ctl[3:2] == 2'b00 && wr_sel[2]) |=> (l2 == $past(wr_data)));
endmodule

bind cmp_latch_group cmp_latch_group_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_ns),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .grp_mode  (grp_mode),
  .ld_ctl    (ld_ctl),
  .at_zero   (at_zero),
  .at_period (at_period),
  .latch_out (latch_out)
);

// File: tb/cmp_latch_group_tb.sv
module cmp_latch_group_tb;
  localparam int W = 16;
  localparam int N = 7;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   wr_sel;
  logic [W-1:0]   wr_data;
  logic [1:0]     grp_mode;
  logic [2*N-1:0] ld_ctl;
  logic           at_zero, at_period, updn_mode;
  logic [W*N-1:0] latch_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  cmp_latch_group #(.DATA_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wr_data(wr_data),
    .grp_mode(grp_mode), .ld_ctl(ld_ctl), .at_zero(at_zero),
    .at_period(at_period), .updn_mode(updn_mode), .latch_out(latch_out)
  );

  task automatic chk(string req, int ch, logic [W-1:0] exp);
    logic [W-1:0] act;
    act = latch_out[W*ch +: W];
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s ch%0d actual=%h expected=%h", req, ch, act, exp);
    end
  endtask

  task automatic wr(int ch, logic [W-1:0] v);
    @(negedge clk);
    wr_sel = '0; wr_sel[ch] = 1'b1; wr_data = v;
    @(negedge clk);
    wr_sel = '0;
  endtask

  task automatic pulse(bit z, bit p);
    @(negedge clk);
    at_zero = z; at_period = p;
    @(negedge clk);
    at_zero = 1'b0; at_period = 1'b0;
  endtask

  task automatic set_ctl(int ch, logic [1:0] v);
    @(negedge clk);
    ld_ctl[2*ch +: 2] = v;
  endtask

  task automatic t_reset();
    for (int c = 0; c < N; c++) chk("R1", c, '0);
  endtask

  task automatic t_direct();
    grp_mode = 2'b00;
    set_ctl(3, 2'b00);
    wr(3, 16'h1234);
    chk("R2", 3, 16'h1234);
  endtask

  task automatic t_zero();
    set_ctl(0, 2'b01);
    wr(0, 16'hAAAA);
    chk("R3", 0, 16'h0000);
    pulse(1'b0, 1'b1);
    chk("R3", 0, 16'h0000);
    pulse(1'b1, 1'b0);
    chk("R3", 0, 16'hAAAA);
  endtask

  task automatic t_mixed();
    set_ctl(5, 2'b10);
    updn_mode = 1'b0;
    wr(5, 16'h0055);
    pulse(1'b0, 1'b1);
    chk("R4", 5, 16'h0000);
    pulse(1'b1, 1'b0);
    chk("R4", 5, 16'h0055);
    updn_mode = 1'b1;
    wr(5, 16'h0066);
    pulse(1'b0, 1'b1);
    chk("R4", 5, 16'h0066);
    updn_mode = 1'b0;
  endtask

  task automatic t_period();
    set_ctl(6, 2'b11);
    wr(6, 16'h0077);
    pulse(1'b1, 1'b0);
    chk("R5", 6, 16'h0000);
    pulse(1'b0, 1'b1);
    chk("R5", 6, 16'h0077);
  endtask

  task automatic t_pairs();
    grp_mode = 2'b01;
    set_ctl(1, 2'b01);
    set_ctl(2, 2'b11);
    wr(1, 16'h0101);
    pulse(1'b1, 1'b0);
    chk("R7", 1, 16'h0000);
    wr(2, 16'h0202);
    pulse(1'b0, 1'b1);
    chk("R6", 2, 16'h0000);
    pulse(1'b1, 1'b0);
    chk("R6", 1, 16'h0101);
    chk("R6", 2, 16'h0202);
    wr(1, 16'h0111);
    pulse(1'b1, 1'b0);
    chk("R12", 1, 16'h0101);
    wr(2, 16'h0202);
    pulse(1'b1, 1'b0);
    chk("R8", 1, 16'h0111);
    chk("R8", 2, 16'h0202);
  endtask

  task automatic t_collide();
    wr(1, 16'h1A1A);
    @(negedge clk);
    wr_sel = 7'b0000100; wr_data = 16'h2B2B; at_zero = 1'b1;
    @(negedge clk);
    wr_sel = '0; at_zero = 1'b0;
    chk("R9", 1, 16'h0111);
    chk("R9", 2, 16'h0202);
    pulse(1'b1, 1'b0);
    chk("R9", 1, 16'h1A1A);
    chk("R9", 2, 16'h2B2B);
  endtask

  task automatic t_wide();
    grp_mode = 2'b10;
    set_ctl(4, 2'b11);
    wr(4, 16'h4444);
    wr(5, 16'h5555);
    pulse(1'b0, 1'b1);
    chk("R10", 4, 16'h0000);
    wr(6, 16'h6666);
    pulse(1'b0, 1'b1);
    chk("R10", 4, 16'h4444);
    chk("R10", 5, 16'h5555);
    chk("R10", 6, 16'h6666);
    grp_mode = 2'b11;
    set_ctl(0, 2'b00);
    for (int c = 1; c < 6; c++) wr(c, 16'h3100 + 16'(c));
    wr(0, 16'h0C0C);
    chk("R10", 0, 16'h0C0C);
    pulse(1'b1, 1'b0);
    chk("R10", 1, 16'h1A1A);
    wr(6, 16'h3106);
    pulse(1'b1, 1'b0);
    for (int c = 1; c < N; c++) chk("R10", c, 16'h3100 + 16'(c));
  endtask

  task automatic t_leader_off();
    grp_mode = 2'b01;
    set_ctl(1, 2'b00);
    set_ctl(2, 2'b11);
    wr(2, 16'h2222);
    chk("R11", 2, 16'h2222);
    chk("R11", 1, 16'h3101);
  endtask

  initial begin
    rst_n = 1'b0; wr_sel = '0; wr_data = '0; grp_mode = 2'b00;
    ld_ctl = '0; at_zero = 1'b0; at_period = 1'b0; updn_mode = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_direct();
    t_zero();
    t_mixed();
    t_period();
    t_pairs();
    t_collide();
    t_wide();
    t_leader_off();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule